// File: doc/BRIEF.md
# Delay-Tap Tuning Register Slave

This block is a small secondary Wishbone pipelined slave. Software, or a calibration helper, uses it to read and adjust the 5-bit delay-tap settings of each data lane of a memory PHY while the chip is running. It holds four tap registers per lane: DQ output delay, DQS output delay, DQ input delay and DQS input delay. It never stalls. Each request is acknowledged in the next cycle, provided the cycle line is still high.

The register is chosen by the low address bits. The lane is not part of the address. Its index is packed into the data word just above the tap value, so a read also carries the lane in its data. A write that lands is passed to the PHY delay loader as a one-cycle update strobe. The strobe comes with the register kind, a one-hot lane select and the new tap count.

An elaboration parameter can remove the port completely. The incoming cycle line is then forced low, so no traffic is ever seen.

Top module: `tap_tune_slave`

## Requirements
- R1: `stall_o` is low in every cycle.
- R2: A request is a cycle in which `cyc_i` and `stb_i` are both high. It is acknowledged by `ack_o` high for exactly one cycle, in the cycle right after the request. `ack_o` is never high without such a request.
- R3: With `PORT_EN` = 0, the block never raises `ack_o` or `upd_o`, and `dat_o` stays 0, whatever the bus does.
- R4: Field layout and register decode:
  - `dat_i[4:0]` holds the tap value.
  - `dat_i[5 +: LW]` holds the lane index, where LW = max(1, ceil(log2(LANES))).
  - `adr_i[4:0]` selects the register: 0 = DQ output delay, 1 = DQS output delay, 2 = DQ input delay, 3 = DQS input delay.
  - Higher address bits and higher data bits are ignored.
- R5: A read is acknowledged with `dat_o` holding the stored tap of the addressed register and lane, zero-extended. In a cycle without `ack_o`, and in a write acknowledge, `dat_o` is 0.
- R6: A write to an implemented register with a valid lane raises `upd_o` for one cycle, in the cycle after its acknowledge. In that same cycle:
  - `upd_kind_o` equals the register number.
  - `upd_lane_o` is one-hot on the lane.
  - `upd_tap_o` carries the new value.
- R7: A request whose lane index is LANES or more is acknowledged. As a write it changes no register and gives no strobe. As a read it returns 0.
- R8: Addresses 4 to 31 in `adr_i[4:0]` are acknowledged. Reads of them return 0, and writes to them have no effect and give no strobe.
- R9: After reset, all taps read 0, and `ack_o` and `upd_o` are low.
- R10: If `cyc_i` is low in the cycle after a request, that request gets no acknowledge, its write is dropped, and no strobe follows.
- R11: A read issued in the cycle after a write to the same register returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W | Register address; bits [4:0] decoded |
| dat_i | input | DATA_W | Tap value and lane index |
| stall_o | output | 1 | Always 0 |
| ack_o | output | 1 | Request acknowledge |
| dat_o | output | DATA_W | Read data, valid with `ack_o` |
| upd_o | output | 1 | Tap update strobe to the PHY |
| upd_kind_o | output | 2 | Register kind being updated |
| upd_lane_o | output | LANES | One-hot lane of the update |
| upd_tap_o | output | 5 | New tap value |

## Verification
The assertions check the handshake timing on every cycle: an acknowledge must follow a request taken one cycle earlier, and must fall while the cycle line is low. They also check that an update strobe always follows an acknowledge, that the lane select is one-hot whenever the strobe is high, and that stored taps stay unchanged when no write fires. Only the bench scenarios can show which value lands in which register and what comes back on reads. That covers field packing, out-of-range lanes and addresses, writes dropped by an abort, back-to-back write-then-read, and a disabled port that stays silent.

// File: rtl/tap_tune_pkg.sv
package tap_tune_pkg;
  localparam int TAP_W = 5;   // tap count width
  localparam int KINDS = 4;   // registers per lane
  localparam int SEL_W = 5;   // decoded address bits

  typedef enum logic [1:0] {
    TK_DQ_OUT  = 2'd0,
    TK_DQS_OUT = 2'd1,
    TK_DQ_IN   = 2'd2,
    TK_DQS_IN  = 2'd3
  } tap_kind_e;
endpackage

// File: rtl/tap_req_stage.sv
module tap_req_stage
  import tap_tune_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cyc_en_i,
  input  logic                stb_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   adr_i,
  input  logic [DATA_W-1:0]   dat_i,
  output logic                hit_o,
  output logic                we_o,
  output tap_kind_e           kind_o,
  output logic                kind_ok_o,
  output logic [LANES-1:0]    lane_oh_o,
  output logic [TAP_W-1:0]    tap_o
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [SEL_W-1:0]  sel;
  logic [LANE_W-1:0] lane;
  logic [LANES-1:0]  lane_oh_d;
  logic              take;
  logic              unused_bits;

  assign sel         = adr_i[SEL_W-1:0];
  assign lane        = dat_i[TAP_W +: LANE_W];
  assign take        = stb_i & cyc_en_i;
  assign unused_bits = ^{adr_i, dat_i};

  // out-of-range lane index decodes to all zero
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_oh_d[g] = (lane == LANE_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= 1'b0;
      we_o      <= 1'b0;
      kind_o    <= TK_DQ_OUT;
      kind_ok_o <= 1'b0;
      lane_oh_o <= '0;
      tap_o     <= '0;
    end else begin
      hit_o <= take;
      if (take) begin
        we_o      <= we_i;
        kind_ok_o <= (sel < SEL_W'(KINDS));
        kind_o    <= tap_kind_e'(sel[1:0]);
        lane_oh_o <= lane_oh_d;
        tap_o     <= dat_i[TAP_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tap_bank.sv
module tap_bank
  import tap_tune_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  tap_kind_e         kind_i,
  input  logic              kind_ok_i,
  input  logic [LANES-1:0]  lane_oh_i,
  input  logic [TAP_W-1:0]  tap_i,
  output logic [TAP_W-1:0]  rd_tap_o
);
  logic [TAP_W-1:0] taps_q [KINDS][LANES];

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic hit_w;
      assign hit_w = wr_en_i & kind_ok_i & (kind_i == tap_kind_e'(k)) & lane_oh_i[l];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    taps_q[k][l] <= '0;
        else if (hit_w) taps_q[k][l] <= tap_i;
      end

      a_r7_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(taps_q[k][l]));
    end
  end

  always_comb begin
    rd_tap_o = '0;
    if (kind_ok_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_oh_i[l]) rd_tap_o = rd_tap_o | taps_q[kind_i][l];
      end
    end
  end
endmodule

// File: rtl/tap_upd_pulse.sv
module tap_upd_pulse
  import tap_tune_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  tap_kind_e         kind_i,
  input  logic [LANES-1:0]  lane_oh_i,
  input  logic [TAP_W-1:0]  tap_i,
  output logic              upd_o,
  output logic [1:0]        upd_kind_o,
  output logic [LANES-1:0]  upd_lane_o,
  output logic [TAP_W-1:0]  upd_tap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_o      <= 1'b0;
      upd_kind_o <= '0;
      upd_lane_o <= '0;
      upd_tap_o  <= '0;
    end else begin
      upd_o      <= fire_i;
      upd_kind_o <= fire_i ? kind_i : 2'd0;
      upd_lane_o <= fire_i ? lane_oh_i : '0;
      upd_tap_o  <= fire_i ? tap_i : '0;
    end
  end

  a_r6_idle_lane_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> (upd_lane_o == '0));
endmodule

// File: rtl/tap_tune_slave.sv
module tap_tune_slave
  import tap_tune_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32,
  parameter bit PORT_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cyc_i,
  input  logic                stb_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   adr_i,
  input  logic [DATA_W-1:0]   dat_i,
  output logic                stall_o,
  output logic                ack_o,
  output logic [DATA_W-1:0]   dat_o,
  output logic                upd_o,
  output logic [1:0]          upd_kind_o,
  output logic [LANES-1:0]    upd_lane_o,
  output logic [TAP_W-1:0]    upd_tap_o
);
  logic             cyc_en;
  logic             hit_q, we_q, kind_ok_q;
  tap_kind_e        kind_q;
  logic [LANES-1:0] lane_oh_q;
  logic [TAP_W-1:0] tap_q, rd_tap;
  logic             fire;

  if (PORT_EN) begin : g_port_on
    assign cyc_en = cyc_i;
  end else begin : g_port_off
    assign cyc_en = 1'b0;
  end

  tap_req_stage #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_en_i(cyc_en), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .dat_i(dat_i), .hit_o(hit_q), .we_o(we_q), .kind_o(kind_q),
    .kind_ok_o(kind_ok_q), .lane_oh_o(lane_oh_q), .tap_o(tap_q)
  );

  // ack qualified by the live cycle line; an abort drops the write too
  assign stall_o = 1'b0;
  assign ack_o   = hit_q & cyc_en;
  assign fire    = ack_o & we_q & kind_ok_q & (|lane_oh_q);
  assign dat_o   = (ack_o && !we_q) ? DATA_W'(rd_tap) : '0;

  tap_bank #(.LANES(LANES)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(fire), .kind_i(kind_q),
    .kind_ok_i(kind_ok_q), .lane_oh_i(lane_oh_q), .tap_i(tap_q), .rd_tap_o(rd_tap)
  );

  tap_upd_pulse #(.LANES(LANES)) u_upd (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .kind_i(kind_q),
    .lane_oh_i(lane_oh_q), .tap_i(tap_q), .upd_o(upd_o), .upd_kind_o(upd_kind_o),
    .upd_lane_o(upd_lane_o), .upd_tap_o(upd_tap_o)
  );

  a_r2_ack_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(stb_i && cyc_i));
  a_r10_ack_needs_cyc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> cyc_i);
  a_r6_upd_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(ack_o && cyc_i));
  a_r6_upd_lane_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> ($countones(upd_lane_o) == 1));
endmodule

// File: tb/sim_tap_tune_slave.sv
module sim_tap_tune_slave;
  localparam int LANES = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cyc_i = 0, stb_i = 0, we_i = 0;
  logic [6:0]  adr_i = '0;
  logic [31:0] dat_i = '0;

  logic        stall_o, ack_o, upd_o;
  logic [31:0] dat_o;
  logic [1:0]  upd_kind_o;
  logic [LANES-1:0] upd_lane_o;
  logic [4:0]  upd_tap_o;

  logic        off_stall, off_ack, off_upd;
  logic [31:0] off_dat;
  logic [1:0]  off_kind;
  logic [LANES-1:0] off_lane;
  logic [4:0]  off_tap;

  always #4 clk_i = ~clk_i;

  tap_tune_slave #(.LANES(LANES)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .dat_i(dat_i), .stall_o(stall_o), .ack_o(ack_o), .dat_o(dat_o),
    .upd_o(upd_o), .upd_kind_o(upd_kind_o), .upd_lane_o(upd_lane_o), .upd_tap_o(upd_tap_o));

  tap_tune_slave #(.LANES(LANES), .PORT_EN(1'b0)) u_off (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .dat_i(dat_i), .stall_o(off_stall), .ack_o(off_ack), .dat_o(off_dat),
    .upd_o(off_upd), .upd_kind_o(off_kind), .upd_lane_o(off_lane), .upd_tap_o(off_tap));

  int total = 0, bad = 0;
  logic [4:0] model [4][LANES];
  bit pv = 0, pwe = 0, pend = 0;
  logic [6:0]  pa = '0;
  logic [31:0] pd = '0;
  logic [1:0]  pend_k = '0;
  logic [LANES-1:0] pend_lane = '0;
  logic [4:0]  pend_tap = '0;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(int lane, int tap, logic [31:0] junk = 0);
    return (junk & 32'hFFFF_FF80) | {25'd0, 2'(lane), 5'(tap)};
  endfunction

  function automatic logic [4:0] model_rd(logic [6:0] a, logic [31:0] d);
    int k = int'(a[4:0]);
    int l = int'(d[6:5]);
    if (k < 4 && l < LANES) return model[k][l];
    return 5'd0;
  endfunction

  task automatic step(bit c, bit s, bit w, logic [6:0] a, logic [31:0] d, string tag);
    bit eack, fire;
    logic [31:0] edat;
    int k, l;
    @(negedge clk_i);
    cyc_i = c; stb_i = s; we_i = w; adr_i = a; dat_i = d;
    #1;
    eack = pv && c;
    edat = (eack && !pwe) ? 32'(model_rd(pa, pd)) : 32'd0;
    chk({tag, "/R1"}, "stall", stall_o, 0);
    chk({tag, "/R2"}, "ack", ack_o, eack);
    chk({tag, "/R5"}, "dat", dat_o, edat);
    chk({tag, "/R6"}, "upd", upd_o, pend);
    if (pend) begin
      chk({tag, "/R6"}, "upd_kind", upd_kind_o, pend_k);
      chk({tag, "/R6"}, "upd_lane", upd_lane_o, pend_lane);
      chk({tag, "/R6"}, "upd_tap", upd_tap_o, pend_tap);
    end
    chk({tag, "/R3"}, "off_ack", off_ack, 0);
    chk({tag, "/R3"}, "off_upd", off_upd, 0);
    chk({tag, "/R3"}, "off_dat", off_dat, 0);
    k = int'(pa[4:0]);
    l = int'(pd[6:5]);
    fire = eack && pwe && k < 4 && l < LANES;
    if (fire) model[k][l] = pd[4:0];
    pend = fire; pend_k = 2'(k); pend_lane = LANES'(1 << l); pend_tap = pd[4:0];
    pv = s && c; pwe = w; pa = a; pd = d;
  endtask

  task automatic idle(string tag);
    step(1, 0, 0, 7'd0, 32'd0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit c, s, w;
    logic [6:0] a;
    logic [31:0] d;
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) for (int l = 0; l < LANES; l++) model[k][l] = '0;
    repeat (3) @(negedge clk_i);
    chk("R9", "ack_in_reset", ack_o, 0);
    chk("R9", "upd_in_reset", upd_o, 0);
    rst_ni = 1'b1;
    idle("R9");
    for (int k = 0; k < 4; k++)
      for (int l = 0; l < LANES; l++) step(1, 1, 0, 7'(k), wd(l, 0), "R9");
    idle("R9");

    // R4: field packing, upper address/data bits ignored
    step(1, 1, 1, 7'h60, wd(2, 21, 32'hABCD_1200), "R4");
    step(1, 1, 0, 7'h20, wd(2, 0, 32'h5555_0000), "R4");
    step(1, 1, 0, 7'h01, wd(2, 0), "R4");
    idle("R4");

    // R6: every kind, back to back
    for (int k = 0; k < 4; k++) step(1, 1, 1, 7'(k), wd(k % LANES, 3 + 7 * k), "R6");
    idle("R6"); idle("R6");

    // R11: write then immediate read
    step(1, 1, 1, 7'd2, wd(1, 30), "R11");
    step(1, 1, 0, 7'd2, wd(1, 0), "R11");
    idle("R11");

    // R7: out-of-range lane
    step(1, 1, 1, 7'd0, wd(3, 17), "R7");
    step(1, 1, 0, 7'd0, wd(3, 0), "R7");
    idle("R7"); idle("R7");

    // R8: unimplemented address
    step(1, 1, 1, 7'd9, wd(0, 11), "R8");
    step(1, 1, 0, 7'd9, wd(0, 0), "R8");
    step(1, 1, 0, 7'd31, wd(1, 0), "R8");
    idle("R8"); idle("R8");

    // R10: cycle dropped in the ack cycle, and strobe with cycle low
    step(1, 1, 1, 7'd0, wd(1, 9), "R10");
    step(0, 0, 0, 7'd0, 32'd0, "R10");
    step(0, 1, 1, 7'd0, wd(1, 12), "R10");
    step(1, 1, 0, 7'd0, wd(1, 0), "R10");
    idle("R10"); idle("R10");

    for (int i = 0; i < 3000; i++) begin
      c = ($urandom % 10) != 0;
      s = ($urandom % 10) < 7;
      w = ($urandom % 2) == 1;
      a = 7'($urandom % 8) | ((($urandom % 8) == 0) ? 7'h40 : 7'h00);
      d = wd(int'($urandom % 4), int'($urandom % 32), $urandom);
      step(c, s, w, a, d, "RND");
    end
    idle("RND"); idle("RND");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule